// File: doc/BRIEF.md
# Chip-Select-Gated Registered Command Buffer

This block is a single-stage register that sits on a memory address/command path. On every rising clock edge it samples a 22-bit data bus, two active-low chip-select lines, two clock-enable lines and two termination-control lines. It drives every sampled value out twice, as an A copy and a B copy, so that two loads can each be fed from their own copy of the same registered value.

A mode input decides how the data bus is captured. In gated mode the data bus is loaded only on edges that carry a valid command, meaning at least one chip select is low. On every other edge the data bus keeps its previous value. In open mode the data bus is loaded on every edge. The chip selects, clock enables and termination lines are always loaded on every edge.

A parity checker tests odd parity over the data bus plus a parity input, on each edge where the data bus is captured. A mismatch shows up later on an active-low error flag. The flag goes low one cycle after the output registers would show the command, and it stays low for two cycles. An active-low asynchronous reset clears all outputs at once and releases the flag.

Top module: `cmd_regbuf`

## Requirements
- R1: All state changes take place on the rising clock edge, and a captured value is visible on the outputs directly after the edge that captured it.
- R2: Each registered output exists as an A copy and a B copy, and the two copies always carry the same value.
- R3: With `gate_en` low, `d` is captured on every rising edge, whatever the value of `cs_n`.
- R4: With `gate_en` high, `d` is captured only on edges where at least one bit of `cs_n` is 0. When `cs_n` is 2'b11 the data outputs keep their previous value.
- R5: `cs_n`, `cke` and `odt` are captured on every rising edge in both modes.
- R6: A parity error is an edge where `d` is captured and the XOR of all 22 bits of `d` and `par_in` equals 0. In gated mode, an edge with `cs_n` = 2'b11 never raises an error.
- R7: For an error sampled at edge k, `perr_n` is 1 after edge k and is 0 directly after edge k+1.
- R8: An isolated error keeps `perr_n` at 0 for exactly two cycles, so `perr_n` returns to 1 after edge k+3.
- R9: An error sampled while the pulse is active restarts the pulse. `perr_n` then returns to 1 three edges after the latest erroneous edge.
- R10: Driving `rst_n` to 0 at once, with no clock edge needed, sets every data, chip-select, clock-enable and termination output to 0 and sets `perr_n` to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| gate_en | input | 1 | 1: gated data capture; 0: capture every edge |
| d | input | 22 | Gated address/command data bus |
| par_in | input | 1 | Parity bit; odd parity with `d` |
| cs_n | input | 2 | Chip selects, active low |
| cke | input | 2 | Clock-enable lines, ungated |
| odt | input | 2 | Termination-control lines, ungated |
| qa_d | output | 22 | Registered data, copy A |
| qb_d | output | 22 | Registered data, copy B |
| qa_cs_n | output | 2 | Registered chip selects, copy A |
| qb_cs_n | output | 2 | Registered chip selects, copy B |
| qa_cke | output | 2 | Registered clock enables, copy A |
| qb_cke | output | 2 | Registered clock enables, copy B |
| qa_odt | output | 2 | Registered termination lines, copy A |
| qb_odt | output | 2 | Registered termination lines, copy B |
| perr_n | output | 1 | Parity error flag, active low |

## Verification
A sweep steps through every pairing of mode and chip-select code. For each pairing it applies several data words, each once with correct parity and once with wrong parity. This separates capture from hold, and reported errors from errors that must be suppressed. Single, overlapping and back-to-back wrong-parity edges are checked against fixed cycle counts, which tell a correct two-cycle pulse with a one-cycle lag from a pulse that is too short, too early or not restarted. An asynchronous reset in the middle of a pulse shows whether the flag and the outputs clear without waiting for a clock edge.

// File: rtl/cmdbuf_pkg.sv
// Package: shared defaults and helpers for the registered command buffer.
// Assumes: odd parity means the XOR over data and parity bit equals 1.
package cmdbuf_pkg;

    localparam int DEF_DATA_W   = 22;  // gated data bus width
    localparam int DEF_RANKS    = 2;   // chip selects / cke / odt lines each
    localparam int DEF_ERR_HOLD = 2;   // cycles the error flag stays low
    localparam int DEF_ERR_LAG  = 1;   // extra cycles before the flag drops

    // Returns 1 when data plus parity bit hold odd parity.
    function automatic logic odd_ok(input logic [DEF_DATA_W-1:0] data,
                                    input logic par);
        return (^data) ^ par;
    endfunction

endpackage

// File: rtl/cmdbuf_capture.sv
// Module: cmdbuf_capture
// Holds the input register stage. The data bus loads under the gating rule
// selected by gate_en; chip selects, clock enables and termination lines
// load on every edge. Exposes the capture decision for the parity checker.
// Assumes: rst_n is asynchronous and active low; all outputs clear to 0.
module cmdbuf_capture #(
    parameter int DATA_W = 22,
    parameter int RANKS  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gate_en,
    input  logic [DATA_W-1:0] d,
    input  logic [RANKS-1:0]  cs_n,
    input  logic [RANKS-1:0]  cke,
    input  logic [RANKS-1:0]  odt,
    output logic              take_data,
    output logic [DATA_W-1:0] data_q,
    output logic [RANKS-1:0]  cs_q,
    output logic [RANKS-1:0]  cke_q,
    output logic [RANKS-1:0]  odt_q
);

    logic cmd_valid;

    // Purpose: decide whether this edge loads the data bus.
    always_comb begin
        cmd_valid = ~(&cs_n);
        take_data = gate_en ? cmd_valid : 1'b1;
    end

    // Purpose: gated data register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (take_data) begin
            data_q <= d;
        end
    end

    // Purpose: ungated control registers, loaded every edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q  <= '0;
            cke_q <= '0;
            odt_q <= '0;
        end else begin
            cs_q  <= cs_n;
            cke_q <= cke;
            odt_q <= odt;
        end
    end

    // R4: deselected edge in gated mode leaves the data unchanged
    a_r4_hold_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en && (&cs_n)) |=> $stable(data_q));

    // R3: open mode follows the bus on every edge
    a_r3_open_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_en |=> (data_q == $past(d)));

    // R5: chip selects always follow their inputs
    a_r5_cs_ungated: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cs_q == $past(cs_n)));

endmodule

// File: rtl/cmdbuf_parity.sv
// Module: cmdbuf_parity
// Checks odd parity on capture edges, delays the result by ERR_LAG cycles
// and stretches it into an ERR_HOLD-cycle active-low flag. A fresh error
// during the pulse restarts the hold count.
// Assumes: rst_n is asynchronous and active low; the flag rests high.
module cmdbuf_parity #(
    parameter int DATA_W   = 22,
    parameter int ERR_HOLD = 2,
    parameter int ERR_LAG  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_data,
    input  logic [DATA_W-1:0] d,
    input  logic              par_in,
    output logic              perr_n
);

    localparam int CNT_W = $clog2(ERR_HOLD + 1);

    logic              bad_now;
    logic [ERR_LAG-1:0] lag_q;
    logic [CNT_W-1:0]   hold_q;

    // Purpose: flag a parity miss on an edge that captures data.
    always_comb begin
        bad_now = take_data & ~((^d) ^ par_in);
    end

    // Purpose: first lag stage.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lag_q[0] <= 1'b0;
        end else begin
            lag_q[0] <= bad_now;
        end
    end

    // Purpose: further lag stages, built only when ERR_LAG exceeds 1.
    for (genvar g = 1; g < ERR_LAG; g++) begin : g_lag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lag_q[g] <= 1'b0;
            end else begin
                lag_q[g] <= lag_q[g-1];
            end
        end
    end

    // Purpose: hold counter that stretches the delayed error.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (lag_q[ERR_LAG-1]) begin
            hold_q <= CNT_W'(ERR_HOLD);
        end else if (hold_q != '0) begin
            hold_q <= hold_q - 1'b1;
        end
    end

    // Purpose: active-low flag from the hold counter.
    always_comb begin
        perr_n = (hold_q == '0);
    end

    // R7: a delayed error always lowers the flag on the next edge
    a_r7_lag_lowers: assert property (@(posedge clk) disable iff (!rst_n)
        lag_q[ERR_LAG-1] |=> !perr_n);

    // R8: once the flag drops it stays low for at least another cycle
    a_r8_min_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(perr_n) |=> !perr_n);

    // R6: an edge that does not capture data starts no error
    a_r6_no_capture_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !take_data |=> !lag_q[0]);

endmodule

// File: rtl/cmdbuf_fanout.sv
// Module: cmdbuf_fanout
// Drives one registered bus onto COPIES identical output copies.
// Assumes: purely combinational; copies are packed side by side.
module cmdbuf_fanout #(
    parameter int W      = 28,
    parameter int COPIES = 2
) (
    input  logic [W-1:0]        src,
    output logic [COPIES*W-1:0] dst
);

    // Purpose: replicate the source into each copy slot.
    for (genvar c = 0; c < COPIES; c++) begin : g_copy
        assign dst[c*W +: W] = src;
    end

endmodule

// File: rtl/cmd_regbuf.sv
// Module: cmd_regbuf (top)
// Registered 1:2 command buffer with chip-select gating of the data bus
// and a delayed, stretched odd-parity error flag.
// Assumes: single clock; rst_n asynchronous, active low.
module cmd_regbuf
    import cmdbuf_pkg::*;
#(
    parameter int DATA_W   = DEF_DATA_W,
    parameter int RANKS    = DEF_RANKS,
    parameter int ERR_HOLD = DEF_ERR_HOLD,
    parameter int ERR_LAG  = DEF_ERR_LAG
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gate_en,
    input  logic [DATA_W-1:0] d,
    input  logic              par_in,
    input  logic [RANKS-1:0]  cs_n,
    input  logic [RANKS-1:0]  cke,
    input  logic [RANKS-1:0]  odt,
    output logic [DATA_W-1:0] qa_d,
    output logic [DATA_W-1:0] qb_d,
    output logic [RANKS-1:0]  qa_cs_n,
    output logic [RANKS-1:0]  qb_cs_n,
    output logic [RANKS-1:0]  qa_cke,
    output logic [RANKS-1:0]  qb_cke,
    output logic [RANKS-1:0]  qa_odt,
    output logic [RANKS-1:0]  qb_odt,
    output logic              perr_n
);

    localparam int BUS_W = DATA_W + 3 * RANKS;

    logic              take_data;
    logic [DATA_W-1:0] data_q;
    logic [RANKS-1:0]  cs_q, cke_q, odt_q;
    logic [BUS_W-1:0]  reg_bus;
    logic [2*BUS_W-1:0] copies;

    cmdbuf_capture #(.DATA_W(DATA_W), .RANKS(RANKS)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .gate_en   (gate_en),
        .d         (d),
        .cs_n      (cs_n),
        .cke       (cke),
        .odt       (odt),
        .take_data (take_data),
        .data_q    (data_q),
        .cs_q      (cs_q),
        .cke_q     (cke_q),
        .odt_q     (odt_q)
    );

    cmdbuf_parity #(.DATA_W(DATA_W), .ERR_HOLD(ERR_HOLD), .ERR_LAG(ERR_LAG)) u_par (
        .clk       (clk),
        .rst_n     (rst_n),
        .take_data (take_data),
        .d         (d),
        .par_in    (par_in),
        .perr_n    (perr_n)
    );

    // Purpose: gather all registered fields into one bus for fan-out.
    always_comb begin
        reg_bus = {data_q, cs_q, cke_q, odt_q};
    end

    cmdbuf_fanout #(.W(BUS_W), .COPIES(2)) u_fan (
        .src (reg_bus),
        .dst (copies)
    );

    // Purpose: split the two copies back into named outputs.
    always_comb begin
        {qa_d, qa_cs_n, qa_cke, qa_odt} = copies[0 +: BUS_W];
        {qb_d, qb_cs_n, qb_cke, qb_odt} = copies[BUS_W +: BUS_W];
    end

    // R1: a captured chip-select code appears on both copies after the edge
    a_r1_cs_both_copies: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (qa_cs_n == $past(cs_n)) && (qb_cs_n == $past(cs_n)));

    // R2: data copies agree on the cycle after any capture
    a_r2_copies_match: assert property (@(posedge clk) disable iff (!rst_n)
        take_data |=> (qa_d == $past(d)) && (qb_d == $past(d)));

endmodule

// File: tb/cmd_regbuf_test.sv
module cmd_regbuf_test;

    localparam int DW = 22;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          gate_en = 1'b0;
    logic [DW-1:0] d = '0;
    logic          par_in = 1'b0;
    logic [1:0]    cs_n = 2'b11;
    logic [1:0]    cke = '0;
    logic [1:0]    odt = '0;
    logic [DW-1:0] qa_d, qb_d;
    logic [1:0]    qa_cs_n, qb_cs_n, qa_cke, qb_cke, qa_odt, qb_odt;
    logic          perr_n;

    int checks = 0;
    int errors = 0;

    // reference model state
    logic [DW-1:0] m_d;
    logic [1:0]    m_cs, m_cke, m_odt;
    logic          m_lag;
    int            m_cnt;

    always #4 clk = ~clk;  // 125 MHz

    cmd_regbuf uut (
        .clk(clk), .rst_n(rst_n), .gate_en(gate_en), .d(d), .par_in(par_in),
        .cs_n(cs_n), .cke(cke), .odt(odt),
        .qa_d(qa_d), .qb_d(qb_d), .qa_cs_n(qa_cs_n), .qb_cs_n(qb_cs_n),
        .qa_cke(qa_cke), .qb_cke(qb_cke), .qa_odt(qa_odt), .qb_odt(qb_odt),
        .perr_n(perr_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_d = '0; m_cs = '0; m_cke = '0; m_odt = '0; m_lag = 1'b0; m_cnt = 0;
    endtask

    // one clock: inputs already driven; model updated at the edge, checked at negedge
    task automatic step();
        logic cap;
        @(posedge clk);
        cap = !gate_en || !(&cs_n);
        if (cap) m_d = d;
        m_cs = cs_n; m_cke = cke; m_odt = odt;
        if (m_lag) m_cnt = 2; else if (m_cnt > 0) m_cnt--;
        m_lag = cap && (((^d) ^ par_in) == 1'b0);
        @(negedge clk);
        chk(gate_en ? "R4 data copy A" : "R3 data copy A", 32'(qa_d), 32'(m_d));
        chk("R2 data copy B", 32'(qb_d), 32'(m_d));
        chk("R5 cs copies", {28'd0, qa_cs_n, qb_cs_n}, {28'd0, m_cs, m_cs});
        chk("R5 cke/odt copies", {24'd0, qa_cke, qb_cke, qa_odt, qb_odt},
            {24'd0, m_cke, m_cke, m_odt, m_odt});
        chk("R8 flag model", 32'(perr_n), 32'(m_cnt == 0));
    endtask

    task automatic drive(input logic g, input logic [1:0] cs, input logic [DW-1:0] dv,
                         input logic good);
        gate_en = g; cs_n = cs; d = dv;
        par_in = good ? ~(^dv) : (^dv);
    endtask

    // watchdog
    initial begin
        #(200000 * 8);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        model_reset();
        #1;
        // R10 / R1: reset state
        chk("R10 reset outputs", {10'd0, qa_d}, 32'd0);
        chk("R10 reset flag", 32'(perr_n), 32'd1);
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;

        // R1: first capture visible right after the edge
        drive(1'b0, 2'b10, 22'h2A5A5A, 1'b1); cke = 2'b01; odt = 2'b10;
        step();
        chk("R1 capture after edge", 32'(qa_d), 32'h2A5A5A);

        // near-exhaustive sweep: mode x cs code x parity x data pattern
        for (int g = 0; g < 2; g++)
            for (int c = 0; c < 4; c++)
                for (int p = 0; p < 2; p++)
                    for (int k = 0; k < 8; k++) begin
                        drive(g[0], c[1:0], DW'((k + 1) * 32'h9E3779B1 + c * 977),
                              p[0]);
                        cke = 2'(k); odt = 2'(k >> 1);
                        step();
                    end
        // drain any pulse
        drive(1'b0, 2'b11, 22'h0, 1'b1);
        repeat (4) step();

        // R6/R7/R8: isolated error, directed timing
        drive(1'b0, 2'b11, 22'h000001, 1'b0);
        step();
        chk("R7 flag high after edge k", 32'(perr_n), 32'd1);
        drive(1'b0, 2'b11, 22'h000003, 1'b1);
        step(); chk("R7 flag low after k+1", 32'(perr_n), 32'd0);
        step(); chk("R8 flag low after k+2", 32'(perr_n), 32'd0);
        step(); chk("R8 flag high after k+3", 32'(perr_n), 32'd1);

        // R6: gated mode, deselected bad parity raises nothing
        drive(1'b1, 2'b11, 22'h0F0F0F, 1'b0);
        step();
        drive(1'b1, 2'b11, 22'h0F0F0E, 1'b1);
        for (int i = 0; i < 3; i++) begin
            step(); chk("R6 deselected no error", 32'(perr_n), 32'd1);
        end
        // R4: data held while deselected
        chk("R4 held value", 32'(qa_d), 32'h3A5A5A ^ 32'h3A5A5A ^ 32'(m_d));

        // R9: errors at k and k+1 (back-to-back), flag high three edges after k+1
        drive(1'b1, 2'b01, 22'h000007, 1'b0);
        step();
        drive(1'b1, 2'b10, 22'h00000F, 1'b0);
        step(); chk("R9 first pulse starts", 32'(perr_n), 32'd0);
        drive(1'b1, 2'b00, 22'h000000, 1'b1);
        step(); chk("R9 low k+2", 32'(perr_n), 32'd0);
        step(); chk("R9 extended low k+3", 32'(perr_n), 32'd0);
        step(); chk("R9 high k+4", 32'(perr_n), 32'd1);

        // R9: error during second cycle of a pulse
        drive(1'b0, 2'b11, 22'h000010, 1'b0); step();   // k
        drive(1'b0, 2'b11, 22'h000030, 1'b1); step();   // k+1 low
        drive(1'b0, 2'b11, 22'h000070, 1'b0); step();   // k+2 low, new error
        drive(1'b0, 2'b11, 22'h0000F0, 1'b1);
        step(); chk("R9 low after k+3", 32'(perr_n), 32'd0);
        step(); chk("R9 low after k+4", 32'(perr_n), 32'd0);
        step(); chk("R9 high after k+5", 32'(perr_n), 32'd1);

        // R10: asynchronous reset in the middle of a pulse
        drive(1'b0, 2'b01, 22'h3FFFFE, 1'b0); cke = 2'b11; odt = 2'b11;
        step(); step();
        chk("R10 pulse active before reset", 32'(perr_n), 32'd0);
        #1 rst_n = 1'b0;
        #1;
        chk("R10 async clears data", {10'd0, qa_d | qb_d}, 32'd0);
        chk("R10 async clears ctrl",
            {20'd0, qa_cs_n, qb_cs_n, qa_cke, qb_cke, qa_odt, qb_odt}, 32'd0);
        chk("R10 async releases flag", 32'(perr_n), 32'd1);
        model_reset();
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        drive(1'b0, 2'b10, 22'h155555, 1'b1);
        repeat (4) step();
        chk("R10 no stale pulse", 32'(perr_n), 32'd1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule